// File: doc/BRIEF.md
# Buck Switching Clock Selector

This block creates the switching tick for a pair of step-down converters. The tick comes either from an on-chip oscillator or from an external synchronisation clock. When the external clock is used, it is divided by three or by six. Two configuration bits choose the source and the ratio. A third bit picks the coupling path for the synchronisation input. All signals are sampled into one system clock domain, and every output is a single-cycle enable in that domain.

Converter A switches on the first enable. Converter B switches on the second enable, which comes half a measured switching period later, so the two converters run out of phase.

The configuration is loaded through a write strobe. While any converter is switching, the stored configuration is frozen. If both select bits are set, the block raises a flag and uses the on-chip oscillator instead.

Top module: `swclk_sel`

## Requirements
- R1: After synchronous reset, the stored configuration is all zero. `clk_en_ph0`, `clk_en_ph1`, `cfg_invalid` and `path_ac` are low.
- R2: Select pattern lo=0, hi=0 uses the oscillator: `clk_en_ph0` pulses once per rising edge of `osc_in`.
- R3: Select pattern lo=1, hi=0 uses the sync input divided by 3: one `clk_en_ph0` pulse every three rising edges of `sync_in`.
- R4: Select pattern lo=0, hi=1 uses the sync input divided by 6: one pulse every six rising edges of `sync_in`.
- R5: Select pattern lo=1, hi=1 is invalid. `cfg_invalid` is high and the tick falls back to the oscillator.
- R6: A write arriving while `reg_running` is high is ignored, and the stored select bits and coupling bit keep their previous values.
- R7: A write arriving while `reg_running` is low loads all three bits on the next clock.
- R8: `clk_en_ph1` pulses once per switching period. It comes floor(P/2) system cycles after `clk_en_ph0`, where P is the measured period in system cycles.
- R9: Both enables are single-cycle pulses and are never high in the same cycle.
- R10: `path_ac` shows the stored coupling-path bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sync_in | input | 1 | External synchronisation clock, sampled |
| osc_in | input | 1 | On-chip oscillator clock, sampled |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_sel_lo | input | 1 | Select bit for divide by 3 |
| cfg_sel_hi | input | 1 | Select bit for divide by 6 |
| cfg_ac | input | 1 | Coupling-path bit (1 = AC path) |
| reg_running | input | 1 | High while any converter is switching |
| clk_en_ph0 | output | 1 | Switching enable for converter A |
| clk_en_ph1 | output | 1 | Half-period shifted enable for converter B |
| cfg_invalid | output | 1 | Both select bits are set |
| path_ac | output | 1 | Stored coupling-path bit |

## Verification
The oscillator runs with a 10-cycle period and the sync input with a 4-cycle period. Each source setting therefore gives its own tick period: 10 for the oscillator and for the invalid fallback, 12 for divide by 3, and 24 for divide by 6. A wrong ratio or a wrong source shows up directly in the measured period. The shift of the second enable is measured in every one of these settings, which tells a true half-period offset apart from a fixed delay. A write made while the converters are running is followed by a period measurement and a read of `path_ac`. A later write with the flag low shows that the freeze lifts again.

// File: rtl/swclk_pkg.sv
package swclk_pkg;

    typedef enum logic [1:0] {
        SRC_OSC    = 2'b00,
        SRC_DIV_LO = 2'b01,
        SRC_DIV_HI = 2'b10,
        SRC_BAD    = 2'b11
    } src_e;

    typedef struct packed {
        logic sel_hi;
        logic sel_lo;
        logic ac;
    } swcfg_t;

    function automatic src_e decode_src(swcfg_t c);
        return src_e'({c.sel_hi, c.sel_lo});
    endfunction

    function automatic logic src_is_div(src_e s);
        return (s == SRC_DIV_LO) || (s == SRC_DIV_HI);
    endfunction

endpackage

// File: rtl/swclk_cfg.sv
module swclk_cfg
    import swclk_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   wr,
    input  swcfg_t wr_data,
    input  logic   running,
    output swcfg_t cfg_q,
    output logic   cfg_chg
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q   <= '0;
            cfg_chg <= 1'b0;
        end else begin
            cfg_chg <= 1'b0;
            if (wr && !running) begin
                cfg_q   <= wr_data;
                cfg_chg <= (wr_data != cfg_q);
            end
        end
    end

    // R6: configuration is frozen whenever a converter runs
    assert_freeze_R6: assert property (@(posedge clk) disable iff (rst)
        running |=> $stable(cfg_q));

    // R7: an accepted write is visible on the next clock
    assert_load_R7: assert property (@(posedge clk) disable iff (rst)
        (wr && !running) |=> (cfg_q == $past(wr_data)));
endmodule

// File: rtl/swclk_edge.sv
module swclk_edge #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic rise
);
    logic [STAGES:0] sh_q;

    always_ff @(posedge clk) begin
        if (rst) sh_q <= '0;
        else     sh_q <= {sh_q[STAGES-1:0], din};
    end

    assign rise = sh_q[STAGES-1] & ~sh_q[STAGES];

    assert_rise_gap_R9: assert property (@(posedge clk) disable iff (rst)
        rise |=> !rise);
endmodule

// File: rtl/swclk_div.sv
module swclk_div #(
    parameter int unsigned DIV_LO = 3,
    parameter int unsigned DIV_HI = 6,
    localparam int unsigned CNT_W = $clog2(DIV_HI)
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic active,
    input  logic use_hi,
    input  logic edge_in,
    output logic tick
);
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] last;

    assign last = use_hi ? CNT_W'(DIV_HI - 1) : CNT_W'(DIV_LO - 1);
    assign tick = active && edge_in && (cnt_q == last);

    always_ff @(posedge clk) begin
        if (rst || clr || !active) begin
            cnt_q <= '0;
        end else if (edge_in) begin
            if (cnt_q >= last) cnt_q <= '0;
            else               cnt_q <= cnt_q + 1'b1;
        end
    end

    // R3 / R4: the count stays inside the chosen ratio
    assert_cnt_range_R3: assert property (@(posedge clk) disable iff (rst || clr)
        (active && !use_hi && !$past(clr) && $past(active) && !$past(use_hi))
        |-> (cnt_q < CNT_W'(DIV_LO)));
    assert_cnt_range_R4: assert property (@(posedge clk) disable iff (rst)
        (active && use_hi) |-> (cnt_q < CNT_W'(DIV_HI)));
endmodule

// File: rtl/swclk_phase.sv
module swclk_phase #(
    parameter int unsigned PER_W = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    output logic en_ph0,
    output logic en_ph1
);
    localparam logic [PER_W-1:0] SAT = {PER_W{1'b1}};

    logic [PER_W-1:0] since_q;
    logic [PER_W-1:0] period_q;
    logic [PER_W-1:0] half;
    logic             hit_half;

    assign half     = period_q >> 1;
    assign hit_half = !tick && (half != '0) && (since_q == half - 1'b1);

    always_ff @(posedge clk) begin
        if (rst) begin
            since_q  <= '0;
            period_q <= '0;
            en_ph0   <= 1'b0;
            en_ph1   <= 1'b0;
        end else begin
            en_ph0 <= tick;
            en_ph1 <= hit_half;
            if (tick) begin
                since_q  <= '0;
                period_q <= (since_q == SAT) ? SAT : since_q + 1'b1;
            end else if (since_q != SAT) begin
                since_q <= since_q + 1'b1;
            end
        end
    end

    assert_no_overlap_R9: assert property (@(posedge clk) disable iff (rst)
        !(en_ph0 && en_ph1));
    assert_ph1_single_R9: assert property (@(posedge clk) disable iff (rst)
        en_ph1 |=> !en_ph1);
    assert_ph1_period_R8: assert property (@(posedge clk) disable iff (rst)
        en_ph1 |-> (period_q >= PER_W'(2)));
endmodule

// File: rtl/swclk_sel.sv
module swclk_sel
    import swclk_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned DIV_LO      = 3,
    parameter int unsigned DIV_HI      = 6,
    parameter int unsigned PER_W       = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic sync_in,
    input  logic osc_in,
    input  logic cfg_wr,
    input  logic cfg_sel_lo,
    input  logic cfg_sel_hi,
    input  logic cfg_ac,
    input  logic reg_running,
    output logic clk_en_ph0,
    output logic clk_en_ph1,
    output logic cfg_invalid,
    output logic path_ac
);
    localparam int unsigned N_SRC   = 2;
    localparam int unsigned IDX_SYN = 0;
    localparam int unsigned IDX_OSC = 1;

    swcfg_t           wr_data;
    swcfg_t           cfg_q;
    logic             cfg_chg;
    src_e             src;
    logic [N_SRC-1:0] raw;
    logic [N_SRC-1:0] rise;
    logic             div_tick;
    logic             tick;

    assign wr_data = '{sel_hi: cfg_sel_hi, sel_lo: cfg_sel_lo, ac: cfg_ac};
    assign raw[IDX_SYN] = sync_in;
    assign raw[IDX_OSC] = osc_in;

    swclk_cfg u_cfg (
        .clk     (clk),
        .rst     (rst),
        .wr      (cfg_wr),
        .wr_data (wr_data),
        .running (reg_running),
        .cfg_q   (cfg_q),
        .cfg_chg (cfg_chg)
    );

    for (genvar g = 0; g < N_SRC; g++) begin : g_edge
        swclk_edge #(.STAGES(SYNC_STAGES)) u_edge (
            .clk  (clk),
            .rst  (rst),
            .din  (raw[g]),
            .rise (rise[g])
        );
    end

    assign src = decode_src(cfg_q);

    swclk_div #(.DIV_LO(DIV_LO), .DIV_HI(DIV_HI)) u_div (
        .clk     (clk),
        .rst     (rst),
        .clr     (cfg_chg),
        .active  (src_is_div(src)),
        .use_hi  (src == SRC_DIV_HI),
        .edge_in (rise[IDX_SYN]),
        .tick    (div_tick)
    );

    always_comb begin
        unique case (src)
            SRC_DIV_LO, SRC_DIV_HI: tick = div_tick;
            default:                tick = rise[IDX_OSC];
        endcase
    end

    swclk_phase #(.PER_W(PER_W)) u_phase (
        .clk    (clk),
        .rst    (rst),
        .tick   (tick),
        .en_ph0 (clk_en_ph0),
        .en_ph1 (clk_en_ph1)
    );

    assign cfg_invalid = (src == SRC_BAD);
    assign path_ac     = cfg_q.ac;

    // R5: the invalid setting never lets the divider drive the tick
    assert_fallback_R5: assert property (@(posedge clk) disable iff (rst)
        (cfg_invalid && div_tick) |-> 1'b0);
    // R2: in oscillator mode every tick stems from an oscillator edge
    assert_osc_tick_R2: assert property (@(posedge clk) disable iff (rst)
        (src == SRC_OSC && tick) |-> rise[IDX_OSC]);
    // R1: no enable in the cycle right after reset
    assert_reset_R1: assert property (@(posedge clk)
        $past(rst) |-> (!clk_en_ph0 && !clk_en_ph1));
endmodule

// File: tb/test_swclk_sel.sv
module test_swclk_sel;
    localparam int OSC_HALF  = 5;
    localparam int SYNC_HALF = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sync_in = 1'b0, osc_in = 1'b0;
    logic cfg_wr = 1'b0, cfg_sel_lo = 1'b0, cfg_sel_hi = 1'b0, cfg_ac = 1'b0;
    logic reg_running = 1'b0;
    logic clk_en_ph0, clk_en_ph1, cfg_invalid, path_ac;

    int n_chk = 0;
    int n_fail = 0;
    int overlap = 0;
    int per, off;

    always #10 clk = ~clk;

    swclk_sel i_swclk_sel (
        .clk(clk), .rst(rst), .sync_in(sync_in), .osc_in(osc_in),
        .cfg_wr(cfg_wr), .cfg_sel_lo(cfg_sel_lo), .cfg_sel_hi(cfg_sel_hi),
        .cfg_ac(cfg_ac), .reg_running(reg_running),
        .clk_en_ph0(clk_en_ph0), .clk_en_ph1(clk_en_ph1),
        .cfg_invalid(cfg_invalid), .path_ac(path_ac)
    );

    initial forever begin repeat (OSC_HALF) @(negedge clk); osc_in = ~osc_in; end
    initial forever begin repeat (SYNC_HALF) @(negedge clk); sync_in = ~sync_in; end

    // R9 monitor: overlap or stretched pulses
    logic ph0_d = 1'b0, ph1_d = 1'b0;
    always @(negedge clk) begin
        if (!rst) begin
            if (clk_en_ph0 && clk_en_ph1) overlap++;
            if (clk_en_ph0 && ph0_d) overlap++;
            if (clk_en_ph1 && ph1_d) overlap++;
        end
        ph0_d = clk_en_ph0;
        ph1_d = clk_en_ph1;
    end

    task automatic chk(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic write_cfg(logic lo, logic hi, logic ac);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_sel_lo = lo; cfg_sel_hi = hi; cfg_ac = ac;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    // period between two ph0 pulses, and ph1 offset after the first
    task automatic measure(output int p, output int o);
        int k;
        p = -1; o = -1;
        repeat (60) @(negedge clk);
        for (int i = 0; i < 200 && !clk_en_ph0; i++) @(negedge clk);
        k = 0;
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            k++;
            if (clk_en_ph1 && o < 0) o = k;
            if (clk_en_ph0) begin p = k; break; end
        end
    endtask

    task automatic t_reset;
        int seen = 0;
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            if (clk_en_ph0 || clk_en_ph1) seen++;
        end
        chk("R1 enables in reset", seen, 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 invalid after reset", cfg_invalid, 0);
        chk("R1 path after reset", path_ac, 0);
    endtask

    task automatic t_osc;
        measure(per, off);
        chk("R2 oscillator period", per, 2 * OSC_HALF);
        chk("R8 oscillator ph1 offset", off, OSC_HALF);
    endtask

    task automatic t_div3;
        write_cfg(1'b1, 1'b0, 1'b1);
        chk("R7 accepted write invalid", cfg_invalid, 0);
        chk("R10 path shows ac", path_ac, 1);
        measure(per, off);
        chk("R3 divide by 3 period", per, 3 * 2 * SYNC_HALF);
        chk("R8 divide by 3 ph1 offset", off, 3 * SYNC_HALF);
    endtask

    task automatic t_frozen;
        reg_running = 1'b1;
        write_cfg(1'b0, 1'b1, 1'b0);
        chk("R6 path unchanged while running", path_ac, 1);
        measure(per, off);
        chk("R6 ratio unchanged while running", per, 3 * 2 * SYNC_HALF);
        write_cfg(1'b1, 1'b1, 1'b0);
        chk("R6 invalid write ignored", cfg_invalid, 0);
        reg_running = 1'b0;
    endtask

    task automatic t_div6;
        write_cfg(1'b0, 1'b1, 1'b0);
        chk("R7 path loaded when idle", path_ac, 0);
        measure(per, off);
        chk("R4 divide by 6 period", per, 6 * 2 * SYNC_HALF);
        chk("R8 divide by 6 ph1 offset", off, 6 * SYNC_HALF);
    endtask

    task automatic t_invalid;
        write_cfg(1'b1, 1'b1, 1'b0);
        chk("R5 invalid flag", cfg_invalid, 1);
        measure(per, off);
        chk("R5 fallback period", per, 2 * OSC_HALF);
        chk("R8 fallback ph1 offset", off, OSC_HALF);
        write_cfg(1'b0, 1'b0, 1'b0);
        chk("R5 flag clears", cfg_invalid, 0);
        measure(per, off);
        chk("R2 oscillator after return", per, 2 * OSC_HALF);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_osc();
        t_div3();
        t_frozen();
        t_div6();
        t_invalid();
        chk("R9 overlap or wide pulse count", overlap, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule